// File: doc/BRIEF.md
# AND-OR Register Read-Bus Combiner

This block merges the read data of several register-holding modules onto one shared read bus. Each source presents a data word and its own enable line, and the enables come from address decoding outside the block. The block does not use tristate drivers or a binary-select multiplexer. It gates every source word with its enable and then folds the gated words together with a wide bitwise reduction. The result is a bus with a defined value when nothing is selected. Because the block takes one enable line per source, it holds no priority encoder and no address decoder.

Two polarities are available. In the active-high build, a gated source shows all zeros when deselected, the reduction is an OR, and the idle bus is all zeros. In the active-low build, a gated source shows all ones when deselected, the reduction is an AND, and the idle bus is all ones. A flag reports any cycle in which more than one source is enabled. An optional output register trades one cycle of latency for a shorter path. Parameter limits are checked at elaboration: 2 to 32 sources and 1 to 64 data bits. A build outside these limits stops with an error.

Top module: `rd_bus_combiner`

## Requirements
- R1: Source s drives bits [s*DATA_W +: DATA_W] of `src_word` and bit s of `src_en`. When exactly one source is enabled, the read bus equals that source's word, and every other source has no effect on it.
- R2: In the active-high build, when several sources are enabled together, the read bus is the bitwise OR of their words.
- R3: In the active-high build, an enable bit of 1 selects its source, and with no bit at 1 the read bus is all zeros.
- R4: In the active-low build, an enable bit of 0 selects its source. The read bus is the bitwise AND of the selected words, and it is all ones when no bit is 0.
- R5: `multi_sel` is 1 exactly when two or more sources are selected, and it is 0 for zero or one selected source.
- R6: With PIPELINE=0, `rd_data` and `multi_sel` follow the inputs in the same cycle, with no register on the path.
- R7: With PIPELINE=1, `rd_data` and `multi_sel` show the value for the inputs sampled at the previous rising clock edge, which is exactly one cycle of latency.
- R8: With PIPELINE=1, a rising edge with `rst` high sets `rd_data` to the idle value of the chosen polarity and clears `multi_sel`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst | input | 1 | Synchronous reset, active high |
| src_en | input | NUM_SRC | One enable per source, polarity set by POLARITY |
| src_word | input | NUM_SRC*DATA_W | Source words packed side by side, source 0 in the low bits |
| rd_data | output | DATA_W | Combined read bus |
| multi_sel | output | 1 | More than one source selected |

## Verification
The bench targets the idle bus in both polarities. A design that left the reduction seeded wrongly, or that used the wrong gate, would show ones on an idle active-high bus or zeros on an idle active-low bus. Collisions of two sources up to all sources would expose a design that picks a single winner by priority instead of merging, or one whose flag fires on a single enable or misses a pair. A side-by-side comparison of a combinational build and a registered build under changing inputs catches latency that is missing or doubled. A reset applied in the middle of traffic catches a register that fails to clear to the idle value of its polarity.

// File: rtl/rbc_pkg.sv
package rbc_pkg;

    typedef enum logic {
        POL_HIGH = 1'b0,
        POL_LOW  = 1'b1
    } pol_e;

    localparam int unsigned MIN_SRC = 2;
    localparam int unsigned MAX_SRC = 32;
    localparam int unsigned MIN_W   = 1;
    localparam int unsigned MAX_W   = 64;

endpackage

// File: rtl/rbc_gate.sv
module rbc_gate
    import rbc_pkg::*;
#(
    parameter int unsigned DATA_W   = 8,
    parameter pol_e        POLARITY = POL_HIGH
) (
    input  logic              en,
    input  logic [DATA_W-1:0] word,
    output logic [DATA_W-1:0] gated
);

    generate
        if (POLARITY == POL_HIGH) begin : g_and_gate
            assign gated = word & {DATA_W{en}};
        end else begin : g_or_gate
            assign gated = word | {DATA_W{en}};
        end
    endgenerate

endmodule

// File: rtl/rbc_reduce.sv
module rbc_reduce
    import rbc_pkg::*;
#(
    parameter int unsigned NUM_SRC  = 4,
    parameter int unsigned DATA_W   = 8,
    parameter pol_e        POLARITY = POL_HIGH
) (
    input  logic [NUM_SRC*DATA_W-1:0] gated,
    output logic [DATA_W-1:0]         merged
);

    generate
        for (genvar b = 0; b < DATA_W; b++) begin : g_bit
            logic [NUM_SRC-1:0] column;
            for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
                assign column[s] = gated[s*DATA_W + b];
            end
            if (POLARITY == POL_HIGH) begin : g_or_fold
                assign merged[b] = |column;
            end else begin : g_and_fold
                assign merged[b] = &column;
            end
        end
    endgenerate

endmodule

// File: rtl/rbc_multi.sv
module rbc_multi
    import rbc_pkg::*;
#(
    parameter int unsigned NUM_SRC  = 4,
    parameter pol_e        POLARITY = POL_HIGH
) (
    input  logic [NUM_SRC-1:0] en,
    output logic               multi
);

    logic [NUM_SRC-1:0] act;
    logic               seen_one;
    logic               seen_two;

    assign act = (POLARITY == POL_LOW) ? ~en : en;

    always_comb begin
        seen_one = 1'b0;
        seen_two = 1'b0;
        for (int s = 0; s < NUM_SRC; s++) begin
            seen_two = seen_two | (seen_one & act[s]);
            seen_one = seen_one | act[s];
        end
    end

    assign multi = seen_two;

endmodule

// File: rtl/rbc_outstage.sv
module rbc_outstage
    import rbc_pkg::*;
#(
    parameter int unsigned DATA_W   = 8,
    parameter bit          PIPELINE = 1'b0,
    parameter pol_e        POLARITY = POL_HIGH
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] d_data,
    input  logic              d_multi,
    output logic [DATA_W-1:0] q_data,
    output logic              q_multi
);

    localparam logic [DATA_W-1:0] IDLE_WORD =
        (POLARITY == POL_LOW) ? {DATA_W{1'b1}} : {DATA_W{1'b0}};

    generate
        if (PIPELINE) begin : g_reg
            always_ff @(posedge clk) begin
                if (rst) begin
                    q_data  <= IDLE_WORD;
                    q_multi <= 1'b0;
                end else begin
                    q_data  <= d_data;
                    q_multi <= d_multi;
                end
            end
        end else begin : g_wire
            logic unused_clk_rst;
            assign unused_clk_rst = clk | rst;
            assign q_data  = d_data;
            assign q_multi = d_multi;
        end
    endgenerate

endmodule

// File: rtl/rd_bus_combiner.sv
module rd_bus_combiner
    import rbc_pkg::*;
#(
    parameter int unsigned NUM_SRC  = 4,
    parameter int unsigned DATA_W   = 32,
    parameter pol_e        POLARITY = POL_HIGH,
    parameter bit          PIPELINE = 1'b0
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [NUM_SRC-1:0]        src_en,
    input  logic [NUM_SRC*DATA_W-1:0] src_word,
    output logic [DATA_W-1:0]         rd_data,
    output logic                      multi_sel
);

    localparam int unsigned BUS_W = NUM_SRC * DATA_W;

    generate
        if (NUM_SRC < MIN_SRC || NUM_SRC > MAX_SRC) begin : g_bad_src
            $error("rd_bus_combiner: NUM_SRC %0d outside supported range", NUM_SRC);
        end
        if (DATA_W < MIN_W || DATA_W > MAX_W) begin : g_bad_w
            $error("rd_bus_combiner: DATA_W %0d outside supported range", DATA_W);
        end
    endgenerate

    logic [BUS_W-1:0]  gated_bus;
    logic [DATA_W-1:0] merged;
    logic              multi_raw;

    generate
        for (genvar s = 0; s < NUM_SRC; s++) begin : g_lane
            rbc_gate #(
                .DATA_W   (DATA_W),
                .POLARITY (POLARITY)
            ) i_gate (
                .en    (src_en[s]),
                .word  (src_word[s*DATA_W +: DATA_W]),
                .gated (gated_bus[s*DATA_W +: DATA_W])
            );
        end
    endgenerate

    rbc_reduce #(
        .NUM_SRC  (NUM_SRC),
        .DATA_W   (DATA_W),
        .POLARITY (POLARITY)
    ) i_reduce (
        .gated  (gated_bus),
        .merged (merged)
    );

    rbc_multi #(
        .NUM_SRC  (NUM_SRC),
        .POLARITY (POLARITY)
    ) i_multi (
        .en    (src_en),
        .multi (multi_raw)
    );

    rbc_outstage #(
        .DATA_W   (DATA_W),
        .PIPELINE (PIPELINE),
        .POLARITY (POLARITY)
    ) i_out (
        .clk     (clk),
        .rst     (rst),
        .d_data  (merged),
        .d_multi (multi_raw),
        .q_data  (rd_data),
        .q_multi (multi_sel)
    );

endmodule

// File: rtl/rd_bus_combiner_chk.sv
module rd_bus_combiner_chk
    import rbc_pkg::*;
#(
    parameter int unsigned NUM_SRC  = 4,
    parameter int unsigned DATA_W   = 32,
    parameter pol_e        POLARITY = POL_HIGH,
    parameter bit          PIPELINE = 1'b0
) (
    input logic                      clk,
    input logic                      rst,
    input logic [NUM_SRC-1:0]        src_en,
    input logic [NUM_SRC*DATA_W-1:0] src_word,
    input logic [DATA_W-1:0]         rd_data,
    input logic                      multi_sel
);

    localparam logic [DATA_W-1:0] IDLE_WORD =
        (POLARITY == POL_LOW) ? {DATA_W{1'b1}} : {DATA_W{1'b0}};

    logic [NUM_SRC-1:0] act;
    assign act = (POLARITY == POL_LOW) ? ~src_en : src_en;

    generate
        if (!PIPELINE) begin : g_comb_chk
            // R3 / R4: idle value with nothing selected
            p_idle_r3: assert property (@(posedge clk) disable iff (rst)
                (act == '0) |-> (rd_data == IDLE_WORD));
            // R5: flag tracks two or more selections
            p_flag_r5: assert property (@(posedge clk) disable iff (rst)
                multi_sel == ($countones(act) > 1));
            for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
                // R1: single selection passes its word
                p_single_r1: assert property (@(posedge clk) disable iff (rst)
                    (act[s] && $countones(act) == 1) |->
                    (rd_data == src_word[s*DATA_W +: DATA_W]));
                if (POLARITY == POL_HIGH) begin : g_hi
                    // R2: every selected word is contained in the bus
                    p_cover_r2: assert property (@(posedge clk) disable iff (rst)
                        act[s] |-> ((rd_data & src_word[s*DATA_W +: DATA_W])
                                    == src_word[s*DATA_W +: DATA_W]));
                end else begin : g_lo
                    // R4: bus is below every selected word
                    p_cover_r4: assert property (@(posedge clk) disable iff (rst)
                        act[s] |-> ((rd_data | src_word[s*DATA_W +: DATA_W])
                                    == src_word[s*DATA_W +: DATA_W]));
                end
            end
        end else begin : g_pipe_chk
            // R8: the cycle after reset shows the idle value
            p_reset_r8: assert property (@(posedge clk) disable iff (rst)
                $past(rst) |-> (rd_data == IDLE_WORD && !multi_sel));
            // R7 / R4: idle one cycle after an empty selection
            p_idle_r7: assert property (@(posedge clk) disable iff (rst)
                (!$past(rst) && $past(act) == '0) |-> (rd_data == IDLE_WORD));
            // R5 / R7: delayed flag
            p_flag_r5: assert property (@(posedge clk) disable iff (rst)
                !$past(rst) |-> (multi_sel == ($countones($past(act)) > 1)));
            for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
                // R1 / R7: single selection appears one cycle later
                p_single_r7: assert property (@(posedge clk) disable iff (rst)
                    (!$past(rst) && $past(act[s]) && $countones($past(act)) == 1) |->
                    (rd_data == $past(src_word[s*DATA_W +: DATA_W])));
            end
        end
    endgenerate

endmodule

bind rd_bus_combiner rd_bus_combiner_chk #(
    .NUM_SRC  (NUM_SRC),
    .DATA_W   (DATA_W),
    .POLARITY (POLARITY),
    .PIPELINE (PIPELINE)
) i_rd_bus_combiner_chk (
    .clk       (clk),
    .rst       (rst),
    .src_en    (src_en),
    .src_word  (src_word),
    .rd_data   (rd_data),
    .multi_sel (multi_sel)
);

// File: tb/test_rd_bus_combiner.sv
`timescale 1ns/1ps
module test_rd_bus_combiner;
    import rbc_pkg::*;

    localparam int unsigned N = 5;
    localparam int unsigned W = 12;
    localparam logic [W-1:0] ONES = {W{1'b1}};

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic [N-1:0]   en_hi = '0;
    logic [N-1:0]   en_lo = '1;
    logic [N*W-1:0] words = '0;
    logic [W-1:0]   hi_data;
    logic           hi_multi;
    logic [W-1:0]   lo_data;
    logic           lo_multi;

    int vectors = 0;
    int miscompares = 0;
    logic [W-1:0] nxt_lo_data = ONES;
    logic         nxt_lo_multi = 1'b0;
    logic [31:0]  lfsr = 32'hACE1_2461;

    always #2 clk = ~clk;

    // active-high, combinational build
    rd_bus_combiner #(.NUM_SRC(N), .DATA_W(W), .POLARITY(POL_HIGH), .PIPELINE(1'b0))
    i_rd_bus_combiner (
        .clk(clk), .rst(rst), .src_en(en_hi), .src_word(words),
        .rd_data(hi_data), .multi_sel(hi_multi)
    );

    // active-low, registered build
    rd_bus_combiner #(.NUM_SRC(N), .DATA_W(W), .POLARITY(POL_LOW), .PIPELINE(1'b1))
    i_rd_bus_combiner_lp (
        .clk(clk), .rst(rst), .src_en(en_lo), .src_word(words),
        .rd_data(lo_data), .multi_sel(lo_multi)
    );

    function automatic logic [W-1:0] model_hi(input logic [N-1:0] e, input logic [N*W-1:0] d);
        logic [W-1:0] acc = '0;
        for (int s = 0; s < N; s++)
            if (e[s]) acc = acc | d[s*W +: W];
        return acc;
    endfunction

    function automatic logic [W-1:0] model_lo(input logic [N-1:0] e_n, input logic [N*W-1:0] d);
        logic [W-1:0] acc = ONES;
        for (int s = 0; s < N; s++)
            if (!e_n[s]) acc = acc & d[s*W +: W];
        return acc;
    endfunction

    function automatic int picks(input logic [N-1:0] e);
        int c = 0;
        for (int s = 0; s < N; s++) if (e[s]) c++;
        return c;
    endfunction

    task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s: got %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic step(input logic r, input logic [N-1:0] sel, input logic [N*W-1:0] d);
        int n;
        logic [W-1:0] exp_lo_data;
        logic         exp_lo_multi;
        @(negedge clk);
        exp_lo_data  = nxt_lo_data;
        exp_lo_multi = nxt_lo_multi;
        rst   = r;
        en_hi = sel;
        en_lo = ~sel;
        words = d;
        #1;
        n = picks(sel);
        if (n == 0)      check("R3/R6 idle bus", hi_data, model_hi(sel, d));
        else if (n == 1) check("R1/R6 single source", hi_data, model_hi(sel, d));
        else             check("R2/R6 OR merge", hi_data, model_hi(sel, d));
        check("R5/R6 flag comb", {{(W-1){1'b0}}, hi_multi}, {{(W-1){1'b0}}, (n > 1)});
        check("R4/R7/R8 registered bus", lo_data, exp_lo_data);
        check("R5/R7/R8 registered flag", {{(W-1){1'b0}}, lo_multi}, {{(W-1){1'b0}}, exp_lo_multi});
        nxt_lo_data  = r ? ONES : model_lo(~sel, d);
        nxt_lo_multi = r ? 1'b0 : (n > 1);
    endtask

    function automatic logic [31:0] lfsr_next(input logic [31:0] v);
        return {v[30:0], v[31] ^ v[21] ^ v[1] ^ v[0]};
    endfunction

    task automatic rand_words(output logic [N*W-1:0] d);
        for (int s = 0; s < N; s++) begin
            lfsr = lfsr_next(lfsr);
            d[s*W +: W] = lfsr[W-1:0] ^ lfsr[31 -: W];
        end
    endtask

    initial begin
        #(200000 * 4);
        miscompares++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        logic [N*W-1:0] d;
        repeat (2) @(posedge clk);
        #1;
        // R8: state after reset edges
        check("R8 reset bus", lo_data, ONES);
        check("R8 reset flag", {{(W-1){1'b0}}, lo_multi}, '0);

        rand_words(d);
        step(1'b1, '0, d);
        step(1'b0, '0, d);                 // R3 / R4 idle both polarities
        step(1'b0, '0, d);
        // R1: each source alone, with the others carrying distinct data
        for (int s = 0; s < N; s++) begin
            rand_words(d);
            step(1'b0, N'(1) << s, d);
        end
        // R2 / R5: pairs and the full set
        d = '0;
        for (int s = 0; s < N; s++) d[s*W +: W] = W'(1) << s;
        step(1'b0, 5'b00011, d);
        step(1'b0, 5'b10100, d);
        step(1'b0, 5'b11111, d);
        for (int s = 0; s < N; s++) d[s*W +: W] = ~(W'(1) << s);
        step(1'b0, 5'b01001, d);
        step(1'b0, 5'b11111, d);
        step(1'b0, 5'b00000, d);
        // mixed traffic
        for (int i = 0; i < 300; i++) begin
            logic [N-1:0] sel;
            rand_words(d);
            lfsr = lfsr_next(lfsr);
            sel = lfsr[N-1:0] & lfsr[N+7:8];
            if (i % 7 == 3) sel = lfsr[N+15:16];
            // R8: reset in the middle of traffic
            step((i == 150 || i == 151), sel, d);
        end
        step(1'b0, '0, d);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule